// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block holds the program counter of a single-issue processor and produces the fetch address for the next cycle on every cycle. It takes decoded control strobes for the instruction at the current fetch address: conditional jump, conditional call, return, and a loop-setup command carrying a last-body address and an iteration count. It also takes a condition-true flag. Each transfer of control completes in the cycle it is decoded, so the pipeline never waits on the sequencer.

Hardware loops close without any branch instruction. A loop-setup command records three values on a small loop stack: the address after the setup instruction as the loop start, the last body address, and the count. Each cycle the current fetch address is compared with the last body address on top of that stack. On a match the sequencer either returns to the loop start and decrements the count, or removes the entry and falls through. No cycle is lost at the loop boundary. A separate return-address stack serves calls. An overflow or underflow on either stack sets a sticky error flag and leaves that stack as it was.

Top module: `zol_seq`

## Requirements
- R1: After reset the fetch address equals `RST_ADDR` (default 0), both error flags are 0, and both stacks are empty.
- R2: With no control strobe active and no loop closing, the fetch address advances by exactly 1 each cycle.
- R3: A jump with `cond_i`=1 makes the next fetch address equal `target_i`.
- R4: A jump or call with `cond_i`=0 behaves like no instruction. The next address is the current address plus 1, or the loop start if a loop closes there. A not-taken call pushes nothing.
- R5: A taken call pushes the current address plus 1 on the return stack and goes to `target_i`. A return goes to the most recently pushed address and removes it. Calls nest.
- R6: A return with an empty return stack sets `unf_o` and advances to the current address plus 1. The return stack is not changed.
- R7: A loop-setup command pushes {current address + 1, `loop_end_i`, `loop_cnt_i`} on the loop stack, and the next address is the current address plus 1.
- R8: When the fetch address equals the top loop's last address and its count is greater than 1, the next address is the top loop's start and the count drops by 1. No cycle is spent.
- R9: When the fetch address equals the top loop's last address and its count is 1 or 0, the entry is removed and the next address is the current address plus 1. A count of 0 or 1 runs the body once.
- R10: The loop stack holds 4 entries. A fifth loop-setup sets `ovf_o`, and the existing loops continue to close as before.
- R11: The return stack holds 16 entries. A 17th nested call sets `ovf_o` but still jumps to `target_i`, and the 16 stored addresses return intact.
- R12: `ovf_o` and `unf_o` stay at 1 once set, and only reset clears them.
- R13: Priority is return, then taken call, then taken jump, then loop setup, then loop closure. Only the winner acts, and at most one loop level closes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jump_i | input | 1 | Conditional jump decoded at the current address |
| call_i | input | 1 | Conditional call decoded at the current address |
| ret_i | input | 1 | Return decoded at the current address |
| do_i | input | 1 | Loop setup decoded at the current address |
| cond_i | input | 1 | Condition result for jump and call |
| target_i | input | AW | Jump or call destination |
| loop_end_i | input | AW | Last body address of the loop being set up |
| loop_cnt_i | input | CW | Iteration count of the loop being set up |
| fetch_addr_o | output | AW | Current fetch address |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The bench goes after the loop boundary. A body run with count 0, 1 and 3 shows whether the design wastes a bubble cycle, loops once too many because it checks after decrementing, or loops forever on a zero count. Nested loops check that the inner entry is removed at its own end address, so the outer loop resumes at its start and not at the inner start. A fifth loop-setup and a 17th call check that an overflowing push leaves the stack alone; a design that overwrote the top entry would fall out of the innermost loop or return to a wrong address. Combined strobes and a not-taken jump placed on a loop's last address expose a wrong priority order or a closure that ignores non-transfer instructions.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_TGT  = 2'd1,
    SRC_RET  = 2'd2,
    SRC_LOOP = 2'd3
  } src_e;

  typedef struct packed {
    logic pc_push;
    logic pc_pop;
    logic lp_push;
    logic lp_pop;
    logic lp_dec;
  } stk_ctl_t;
endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         upd_i,
  input  logic [W-1:0] push_data_i,
  input  logic [W-1:0] upd_data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNTW-1:0] cnt_q;
  logic [IW-1:0]   top_idx, wr_idx;
  logic [W-1:0]    ent_q [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign top_idx = IW'(cnt_q - CNTW'(1));
  assign wr_idx  = IW'(cnt_q);
  assign top_o   = empty_o ? '0 : ent_q[top_idx];
  assign ovf_o   = push_i & full_o;
  assign unf_o   = pop_i & empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i) begin
      if (!full_o) cnt_q <= cnt_q + CNTW'(1);
    end else if (pop_i) begin
      if (!empty_o) cnt_q <= cnt_q - CNTW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_push, wr_upd;
    assign wr_push = push_i && !full_o && (wr_idx == IW'(g));
    assign wr_upd  = !push_i && !pop_i && upd_i && !empty_o && (top_idx == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q[g] <= '0;
      else if (wr_push) ent_q[g] <= push_data_i;
      else if (wr_upd)  ent_q[g] <= upd_data_i;
    end
  end
endmodule

// File: rtl/zol_next.sv
module zol_next
  import zol_pkg::*;
#(
  parameter int AW = 14,
  parameter int CW = 14
) (
  input  logic [AW-1:0] pc_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          do_i,
  input  logic          cond_i,
  input  logic          pc_empty_i,
  input  logic          lp_empty_i,
  input  logic [AW-1:0] lp_end_i,
  input  logic [CW-1:0] lp_cnt_i,
  output src_e          sel_o,
  output stk_ctl_t      ctl_o
);
  logic lp_hit;
  assign lp_hit = !lp_empty_i && (pc_i == lp_end_i);

  always_comb begin
    sel_o = SRC_SEQ;
    ctl_o = '0;
    if (ret_i) begin
      ctl_o.pc_pop = 1'b1;
      sel_o = pc_empty_i ? SRC_SEQ : SRC_RET;
    end else if (call_i && cond_i) begin
      ctl_o.pc_push = 1'b1;
      sel_o = SRC_TGT;
    end else if (jump_i && cond_i) begin
      sel_o = SRC_TGT;
    end else if (do_i) begin
      ctl_o.lp_push = 1'b1;
    end else if (lp_hit) begin
      if (lp_cnt_i > CW'(1)) begin
        ctl_o.lp_dec = 1'b1;
        sel_o = SRC_LOOP;
      end else begin
        ctl_o.lp_pop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq
  import zol_pkg::*;
#(
  parameter int          AW         = 14,
  parameter int          CW         = 14,
  parameter int          PC_DEPTH   = 16,
  parameter int          LOOP_DEPTH = 4,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          do_i,
  input  logic          cond_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] loop_end_i,
  input  logic [CW-1:0] loop_cnt_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int LW = 2 * AW + CW;

  logic [AW-1:0] pc_q, pc_inc, pc_nxt, pc_top;
  logic [LW-1:0] lp_top, lp_push_data, lp_upd_data;
  logic [AW-1:0] lp_start, lp_end;
  logic [CW-1:0] lp_cnt;
  logic          pc_empty, pc_full, pc_ovf, pc_unf;
  logic          lp_empty, lp_full, lp_ovf, lp_unf;
  logic          ovf_q, unf_q;
  src_e          sel;
  stk_ctl_t      ctl;

  assign pc_inc   = pc_q + AW'(1);
  assign lp_start = lp_top[LW-1 -: AW];
  assign lp_end   = lp_top[AW+CW-1 -: AW];
  assign lp_cnt   = lp_top[CW-1:0];

  assign lp_push_data = {pc_inc, loop_end_i, loop_cnt_i};
  assign lp_upd_data  = {lp_start, lp_end, lp_cnt - CW'(1)};

  zol_next #(.AW(AW), .CW(CW)) u_next (
    .pc_i       (pc_q),
    .jump_i     (jump_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .do_i       (do_i),
    .cond_i     (cond_i),
    .pc_empty_i (pc_empty),
    .lp_empty_i (lp_empty),
    .lp_end_i   (lp_end),
    .lp_cnt_i   (lp_cnt),
    .sel_o      (sel),
    .ctl_o      (ctl)
  );

  // return-address stack
  zol_stack #(.W(AW), .DEPTH(PC_DEPTH)) u_pc_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ctl.pc_push),
    .pop_i       (ctl.pc_pop),
    .upd_i       (1'b0),
    .push_data_i (pc_inc),
    .upd_data_i  ('0),
    .top_o       (pc_top),
    .empty_o     (pc_empty),
    .full_o      (pc_full),
    .ovf_o       (pc_ovf),
    .unf_o       (pc_unf)
  );

  // loop stack: {start, last, count}
  zol_stack #(.W(LW), .DEPTH(LOOP_DEPTH)) u_lp_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ctl.lp_push),
    .pop_i       (ctl.lp_pop),
    .upd_i       (ctl.lp_dec),
    .push_data_i (lp_push_data),
    .upd_data_i  (lp_upd_data),
    .top_o       (lp_top),
    .empty_o     (lp_empty),
    .full_o      (lp_full),
    .ovf_o       (lp_ovf),
    .unf_o       (lp_unf)
  );

  always_comb begin
    unique case (sel)
      SRC_TGT:  pc_nxt = target_i;
      SRC_RET:  pc_nxt = pc_top;
      SRC_LOOP: pc_nxt = lp_start;
      default:  pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RST_ADDR;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_nxt;
      ovf_q <= ovf_q | pc_ovf | lp_ovf;
      unf_q <= unf_q | pc_unf | lp_unf;
    end
  end

  assign fetch_addr_o = pc_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
  parameter int AW = 14,
  parameter int CW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          jump_i,
  input logic          call_i,
  input logic          ret_i,
  input logic          do_i,
  input logic          cond_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic          ovf_o,
  input logic          unf_o,
  input logic          pc_empty,
  input logic [AW-1:0] pc_top,
  input logic          lp_empty,
  input logic [AW-1:0] lp_start,
  input logic [AW-1:0] lp_end,
  input logic [CW-1:0] lp_cnt
);
  logic quiet, at_end;
  assign quiet  = !ret_i && !(call_i && cond_i) && !(jump_i && cond_i) && !do_i;
  assign at_end = !lp_empty && (fetch_addr_o == lp_end);

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !at_end) |=> fetch_addr_o == AW'($past(fetch_addr_o) + AW'(1))); // R2

  AST_JUMP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_i && jump_i && cond_i) |=> fetch_addr_o == $past(target_i)); // R3

  AST_CALL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ret_i && call_i && cond_i) |=> fetch_addr_o == $past(target_i)); // R5

  AST_RET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !pc_empty) |=> fetch_addr_o == $past(pc_top)); // R5

  AST_RET_EMPTY_UNF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && pc_empty) |=> unf_o); // R6

  AST_LOOP_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && at_end && lp_cnt > CW'(1)) |=> fetch_addr_o == $past(lp_start)); // R8

  AST_LOOP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && at_end && lp_cnt <= CW'(1)) |=> fetch_addr_o == AW'($past(fetch_addr_o) + AW'(1))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R12

  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o); // R12
endmodule

bind zol_seq zol_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .jump_i       (jump_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .do_i         (do_i),
  .cond_i       (cond_i),
  .target_i     (target_i),
  .fetch_addr_o (fetch_addr_o),
  .ovf_o        (ovf_o),
  .unf_o        (unf_o),
  .pc_empty     (pc_empty),
  .pc_top       (pc_top),
  .lp_empty     (lp_empty),
  .lp_start     (lp_start),
  .lp_end       (lp_end),
  .lp_cnt       (lp_cnt)
);

// File: tb/zol_seq_test.sv
`timescale 1ns/1ps
module zol_seq_test;
  localparam int AW = 14;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic jump_i = 0, call_i = 0, ret_i = 0, do_i = 0, cond_i = 0;
  logic [AW-1:0] target_i = '0, loop_end_i = '0;
  logic [CW-1:0] loop_cnt_i = '0;
  logic [AW-1:0] fetch_addr_o;
  logic ovf_o, unf_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  zol_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
    .do_i(do_i), .cond_i(cond_i), .target_i(target_i), .loop_end_i(loop_end_i),
    .loop_cnt_i(loop_cnt_i), .fetch_addr_o(fetch_addr_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit j, bit c, bit r, bit d, bit cd, int tgt, int le, int lc);
    jump_i = j; call_i = c; ret_i = r; do_i = d; cond_i = cd;
    target_i = tgt[AW-1:0]; loop_end_i = le[AW-1:0]; loop_cnt_i = lc[CW-1:0];
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    jump_i = 0; call_i = 0; ret_i = 0; do_i = 0; cond_i = 0;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 fetch", int'(fetch_addr_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 unf", int'(unf_o), 0);
  endtask

  task automatic t_seq();
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      idle();
      chk("R2", int'(fetch_addr_o), i);
    end
  endtask

  task automatic t_jump();
    do_reset();
    drive(1, 0, 0, 0, 1, 100, 0, 0);
    chk("R3", int'(fetch_addr_o), 100);
    drive(1, 0, 0, 0, 0, 300, 0, 0);
    chk("R4 jump", int'(fetch_addr_o), 101);
    drive(0, 1, 0, 0, 0, 300, 0, 0);
    chk("R4 call", int'(fetch_addr_o), 102);
    drive(0, 0, 1, 0, 0, 0, 0, 0);   // nothing was pushed by the not-taken call
    chk("R4 no push", int'(unf_o), 1);
  endtask

  task automatic t_call_ret();
    do_reset();
    idle();
    drive(0, 1, 0, 0, 1, 200, 0, 0);
    chk("R5 call", int'(fetch_addr_o), 200);
    idle();
    drive(0, 1, 0, 0, 1, 400, 0, 0);
    chk("R5 nested call", int'(fetch_addr_o), 400);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 inner ret", int'(fetch_addr_o), 202);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 outer ret", int'(fetch_addr_o), 2);
    chk("R5 flags", int'({ovf_o, unf_o}), 0);
  endtask

  task automatic t_ret_empty();
    do_reset();
    idle();
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 addr", int'(fetch_addr_o), 2);
    chk("R6 unf", int'(unf_o), 1);
    repeat (3) idle();
    chk("R12 unf sticky", int'(unf_o), 1);
    drive(0, 1, 0, 0, 1, 50, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 stack intact", int'(fetch_addr_o), 6);
  endtask

  task automatic t_loop(int cnt);
    int iters;
    iters = (cnt < 1) ? 1 : cnt;
    do_reset();
    drive(1, 0, 0, 0, 1, 20, 0, 0);
    drive(0, 0, 0, 1, 0, 0, 23, cnt);
    chk("R7 setup", int'(fetch_addr_o), 21);
    for (int it = 0; it < iters; it++) begin
      for (int a = 21; a <= 23; a++) begin
        if (it == 0 && a == 21) continue;
        idle();
        chk((a == 21) ? "R8 loop back" : "R7 body", int'(fetch_addr_o), a);
      end
    end
    idle();
    chk("R9 exit", int'(fetch_addr_o), 24);
    idle();
    chk("R9 popped", int'(fetch_addr_o), 25);
  endtask

  task automatic t_nested();
    int exp_a [20];
    int n;
    n = 0;
    for (int o = 0; o < 2; o++) begin
      exp_a[n++] = 11;
      for (int i = 0; i < 3; i++) begin
        exp_a[n++] = 12;
        exp_a[n++] = 13;
      end
      exp_a[n++] = 14;
    end
    exp_a[n++] = 15;
    do_reset();
    drive(1, 0, 0, 0, 1, 10, 0, 0);
    for (int k = 0; k < n; k++) begin
      if (int'(fetch_addr_o) == 10)      drive(0, 0, 0, 1, 0, 0, 14, 2);
      else if (int'(fetch_addr_o) == 11) drive(0, 0, 0, 1, 0, 0, 13, 3);
      else                               idle();
      chk("R8 nested", int'(fetch_addr_o), exp_a[k]);
    end
  endtask

  task automatic t_loop_ovf();
    do_reset();
    drive(1, 0, 0, 0, 1, 50, 0, 0);
    drive(0, 0, 0, 1, 0, 0, 90, 2);
    drive(0, 0, 0, 1, 0, 0, 80, 2);
    drive(0, 0, 0, 1, 0, 0, 70, 2);
    drive(0, 0, 0, 1, 0, 0, 55, 2);
    chk("R10 four fit", int'(ovf_o), 0);
    drive(0, 0, 0, 1, 0, 0, 60, 5);
    chk("R10 fifth ovf", int'(ovf_o), 1);
    chk("R10 addr", int'(fetch_addr_o), 55);
    idle();
    chk("R10 top intact", int'(fetch_addr_o), 54);
    idle();
    chk("R10 body", int'(fetch_addr_o), 55);
    idle();
    chk("R10 exit", int'(fetch_addr_o), 56);
    chk("R12 ovf sticky", int'(ovf_o), 1);
  endtask

  task automatic t_pc_ovf();
    do_reset();
    for (int k = 0; k <= 16; k++) begin
      drive(0, 1, 0, 0, 1, 2 * k + 2, 0, 0);
      chk("R11 call", int'(fetch_addr_o), 2 * k + 2);
      chk("R11 ovf", int'(ovf_o), (k == 16) ? 1 : 0);
    end
    for (int k = 15; k >= 0; k--) begin
      drive(0, 0, 1, 0, 0, 0, 0, 0);
      chk("R11 ret", int'(fetch_addr_o), 2 * k + 1);
    end
    chk("R11 no unf", int'(unf_o), 0);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 drained", int'(unf_o), 1);
    chk("R6 drained addr", int'(fetch_addr_o), 2);
    do_reset();
    chk("R12 reset clears", int'({ovf_o, unf_o}), 0);
  endtask

  task automatic t_prio();
    do_reset();
    idle();
    drive(0, 1, 0, 0, 1, 40, 0, 0);
    drive(1, 1, 1, 0, 1, 90, 0, 0);
    chk("R13 ret wins", int'(fetch_addr_o), 2);
    drive(1, 1, 0, 0, 1, 60, 0, 0);
    chk("R13 call target", int'(fetch_addr_o), 60);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R13 call pushed", int'(fetch_addr_o), 3);
    drive(1, 0, 0, 1, 1, 80, 81, 3);
    chk("R13 jump over do", int'(fetch_addr_o), 80);
    idle();
    idle();
    chk("R13 no loop", int'(fetch_addr_o), 82);
    drive(0, 0, 0, 1, 0, 0, 84, 2);
    idle();
    chk("R7 body", int'(fetch_addr_o), 84);
    drive(1, 0, 0, 0, 0, 500, 0, 0);
    chk("R4 closes loop", int'(fetch_addr_o), 83);
    idle();
    idle();
    chk("R9 after close", int'(fetch_addr_o), 85);
    chk("R13 flags", int'({ovf_o, unf_o}), 0);
  endtask

  initial begin
    #(60000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_jump();
    t_call_ret();
    t_ret_empty();
    t_loop(3);
    t_loop(1);
    t_loop(0);
    t_nested();
    t_loop_ovf();
    t_pc_ovf();
    t_prio();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule